// File: doc/BRIEF.md
# Conversion Start Controller with Trigger Gating

This block holds the 8-bit control word that launches an analog-to-digital conversion. The word carries three live fields: a trigger-enable flag, a converter clock-select flag and a go/busy flag. A conversion begins in one of three ways. Software can write a 1 to the go flag. A falling edge on an active-low external trigger pin can start it. A pulse from an internal timer can also start it. A source-select input decides which of the two hardware sources is listened to.

While the go flag is set, the converter is treated as busy. Hardware triggers are ignored during that time, and the clock-select field is frozen. The flag drops when the converter signals completion, or when software writes a 0 to abort the conversion. The start output gives one pulse per new conversion. The converter, its analog front end and its result storage are outside this block.

Top module: `adc_start_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x1F, `clk_sel_o` is 0 and `start_o` is 0.
- R2: If `standby_i` is high at a clock edge, the control word reads 0x1F from the next cycle, whatever else is driven in that cycle.
- R3: Read layout: bit 7 is trigger enable, bit 6 is clock select and bit 5 is go/busy. Bits 4..0 always read 1, and writes to them have no effect.
- R4: A write (`reg_wr`=1) with bit 5 set while idle sets go/busy at that edge. `start_o` is high during the first cycle in which go/busy reads 1.
- R5: With trigger enable 1 and `src_sel_i`=0 (external pin), a falling edge of `trig_n_i` sets go/busy. The pin is passed through a two-flop synchronizer, and the flag is set on the third clock edge after the pin falls. The pin must be low for at least 2 clocks.
- R6: While go/busy is 1, edges on the selected hardware trigger are ignored: there is no further `start_o` and the word is unchanged.
- R7: With trigger enable 0, neither the external pin nor the timer trigger can set go/busy.
- R8: With `src_sel_i`=1, a high cycle of `tmr_trig_i` sets go/busy at that edge and the external pin is ignored. With `src_sel_i`=0, `tmr_trig_i` is ignored.
- R9: A high cycle of `conv_done_i` clears go/busy. A write with bit 5 clear also clears it (abort). A register write takes priority over done and triggers in the same cycle.
- R10: Writing bit 5 = 1 while go/busy is already 1 leaves it set and produces no `start_o` pulse.
- R11: Clock select follows bit 6 of a write only while go/busy is 0. `clk_sel_o` always equals the stored bit 6.
- R12: `start_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry; synchronously reloads the control word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| trig_n_i | input | 1 | Asynchronous active-low external trigger pin |
| tmr_trig_i | input | 1 | Synchronous timer trigger pulse |
| src_sel_i | input | 1 | Hardware trigger source: 0 pin, 1 timer |
| conv_done_i | input | 1 | Conversion complete pulse |
| start_o | output | 1 | One-cycle conversion start pulse |
| clk_sel_o | output | 1 | Converter clock select |

## Verification
The bench drives a pin edge while a conversion is already running. A design that fails to gate on busy would emit a second start pulse. It writes clock select during a conversion, which a design without the freeze would let change the converter clock mid-conversion. It rewrites the go bit as 1 while busy, which a naive edge detector would turn into a restart. It feeds each hardware source while the other source is selected, and with trigger enable off, to expose routing that leaks the wrong trigger. Random write, done, timer and standby traffic then checks the write-over-done priority and the reserved bits against a model.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
   localparam int unsigned CW_W    = 8;
   localparam int unsigned B_TEN   = 7;
   localparam int unsigned B_CKS   = 6;
   localparam int unsigned B_GO    = 5;
   localparam int unsigned RSV_W   = 5;
   localparam logic [CW_W-1:0] CW_RESET = 8'h1F;

   typedef struct packed {
      logic ten;
      logic cks;
      logic go;
   } cw_t;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_TMR = 1'b1
   } src_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad
      $error("trig_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         last_q <= 1'b1;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_n};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~sh_q[STAGES-1];

   p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/trig_route.sv
module trig_route #(
   parameter bit TMR_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_fall,
   input  logic tmr,
   input  logic src_sel,
   input  logic enable,
   output logic hit_o
);
   import adc_start_pkg::*;

   logic tmr_ev;

   if (TMR_EDGE) begin : g_tmr_edge
      logic tmr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tmr_q <= 1'b0;
         else        tmr_q <= tmr;
      end
      assign tmr_ev = tmr & ~tmr_q;
   end else begin : g_tmr_level
      assign tmr_ev = tmr;
   end

   always_comb begin
      unique case (src_e'(src_sel))
         SRC_TMR: hit_o = enable & tmr_ev;
         default: hit_o = enable & pin_fall;
      endcase
   end

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !hit_o);
endmodule

// File: rtl/ctl_word.sv
module ctl_word (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby,
   input  logic                 wr,
   input  adc_start_pkg::cw_t   wfields,
   input  logic                 hit,
   input  logic                 done,
   output adc_start_pkg::cw_t   cw_o
);
   import adc_start_pkg::*;

   cw_t cw_q, cw_d;
   localparam cw_t CW_INIT = '{ten: CW_RESET[B_TEN], cks: CW_RESET[B_CKS], go: CW_RESET[B_GO]};

   always_comb begin
      cw_d = cw_q;
      if (standby) begin
         cw_d = CW_INIT;
      end else if (wr) begin
         cw_d.ten = wfields.ten;
         cw_d.go  = wfields.go;
         if (!cw_q.go) cw_d.cks = wfields.cks;
      end else if (done) begin
         cw_d.go = 1'b0;
      end else if (hit && !cw_q.go) begin
         cw_d.go = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cw_q <= CW_INIT;
      else        cw_q <= cw_d;
   end

   assign cw_o = cw_q;

   p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (cw_o == CW_INIT));
   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_q.go && !wr && !done && !standby) |=> cw_q.go);
   p_no_trig_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw_q.ten && !cw_q.go && !wr && !standby) |=> !cw_q.go);
   p_done_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr) |=> !cw_q.go);
   p_cks_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_q.go && !standby) |=> $stable(cw_q.cks));
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TMR_EDGE    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       standby_i,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       trig_n_i,
   input  logic       tmr_trig_i,
   input  logic       src_sel_i,
   input  logic       conv_done_i,
   output logic       start_o,
   output logic       clk_sel_o
);
   import adc_start_pkg::*;

   if (CW_W != 8) begin : g_bad_w
      $error("adc_start_ctl: control word must be 8 bits");
   end

   cw_t  cw, wf;
   logic pin_fall, hit, go_dly_q;
   wire  unused_rsv = &{1'b0, reg_wdata[RSV_W-1:0]};

   assign wf = '{ten: reg_wdata[B_TEN], cks: reg_wdata[B_CKS], go: reg_wdata[B_GO]};

   trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (trig_n_i),
      .fall_o(pin_fall)
   );

   trig_route #(.TMR_EDGE(TMR_EDGE)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_fall(pin_fall),
      .tmr     (tmr_trig_i),
      .src_sel (src_sel_i),
      .enable  (cw.ten),
      .hit_o   (hit)
   );

   ctl_word u_cw (
      .clk    (clk),
      .rst_n  (rst_n),
      .standby(standby_i),
      .wr     (reg_wr),
      .wfields(wf),
      .hit    (hit),
      .done   (conv_done_i),
      .cw_o   (cw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         go_dly_q <= 1'b0;
      else if (standby_i) go_dly_q <= 1'b0;
      else                go_dly_q <= cw.go;
   end

   assign start_o   = cw.go & ~go_dly_q;
   assign clk_sel_o = cw.cks;
   assign reg_rdata = {cw.ten, cw.cks, cw.go, {RSV_W{1'b1}}};

   p_start_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   p_rewrite_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.go && reg_wr && reg_wdata[B_GO] && !standby_i) |=> !start_o);
endmodule

// File: tb/sim_adc_start_ctl.sv
module sim_adc_start_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby_i = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       trig_n_i = 1'b1, tmr_trig_i = 1'b0, src_sel_i = 1'b0, conv_done_i = 1'b0;
   logic       start_o, clk_sel_o;
   int         checks = 0, errors = 0;
   int         starts;

   always #4 clk = ~clk;

   adc_start_ctl u0 (.*);

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (start_o) starts++;
      end
   endtask

   task automatic wr(logic [7:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic done_pulse();
      conv_done_i = 1'b1;
      @(negedge clk);
      conv_done_i = 1'b0;
   endtask

   function automatic logic [2:0] model_next(logic [2:0] s, logic w, logic [7:0] d,
                                             logic tmr, logic dn, logic sb);
      logic [2:0] n = s;
      if (sb) n = 3'b000;
      else if (w) begin
         n[2] = d[7]; n[0] = d[5];
         if (!s[0]) n[1] = d[6];
      end else if (dn) n[0] = 1'b0;
      else if (s[2] && tmr && !s[0]) n[0] = 1'b1;
      return n;
   endfunction

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] ms;
      logic       mprev, rw, rt, rd, rs;
      logic [7:0] rdv;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset word", reg_rdata, 8'h1F);
      check("R1 clk_sel", {7'd0, clk_sel_o}, 8'h00);
      check("R1 start", {7'd0, start_o}, 8'h00);

      reg_wr = 1'b1; reg_wdata = 8'hFF;
      @(negedge clk); reg_wr = 1'b0;
      check("R4 go set", reg_rdata, 8'hFF);
      check("R4 start pulse", {7'd0, start_o}, 8'h01);
      check("R11 clk_sel out", {7'd0, clk_sel_o}, 8'h01);
      @(negedge clk);
      check("R12 start width", {7'd0, start_o}, 8'h00);
      starts = 0;
      reg_wr = 1'b1; reg_wdata = 8'hA0;
      @(negedge clk); reg_wr = 1'b0;
      if (start_o) starts++;
      check("R10 R11 rewrite busy", reg_rdata, 8'hFF);
      check("R10 no restart", starts[7:0], 8'd0);
      done_pulse();
      check("R9 done clears", reg_rdata, 8'hDF);
      wr(8'h80);
      check("R11 cks idle write", reg_rdata, 8'h9F);
      check("R3 reserved ones", reg_rdata & 8'h1F, 8'h1F);

      src_sel_i = 1'b0; starts = 0;
      trig_n_i = 1'b0;
      cyc(2); check("R5 not yet after 2", reg_rdata, 8'h9F);
      cyc(1); check("R5 set on third edge", reg_rdata, 8'hBF);
      trig_n_i = 1'b1;
      cyc(4); check("R5 one start", starts[7:0], 8'd1);
      starts = 0;
      trig_n_i = 1'b0; cyc(3); trig_n_i = 1'b1;
      tmr_trig_i = 1'b1; cyc(1); tmr_trig_i = 1'b0; cyc(4);
      check("R6 busy ignores edge", starts[7:0], 8'd0);
      check("R6 word unchanged", reg_rdata, 8'hBF);
      done_pulse();

      starts = 0;
      tmr_trig_i = 1'b1; cyc(1); tmr_trig_i = 1'b0; cyc(2);
      check("R8 timer ignored on pin src", reg_rdata, 8'h9F);
      src_sel_i = 1'b1;
      trig_n_i = 1'b0; cyc(3); trig_n_i = 1'b1; cyc(4);
      check("R8 pin ignored on timer src", reg_rdata, 8'h9F);
      tmr_trig_i = 1'b1; cyc(1); tmr_trig_i = 1'b0;
      check("R8 timer starts", reg_rdata, 8'hBF);
      check("R8 start count", starts[7:0], 8'd1);
      done_pulse();

      wr(8'h00);
      tmr_trig_i = 1'b1; cyc(1); tmr_trig_i = 1'b0; cyc(1);
      src_sel_i = 1'b0;
      trig_n_i = 1'b0; cyc(3); trig_n_i = 1'b1; cyc(4);
      check("R7 disabled triggers", reg_rdata, 8'h1F);

      wr(8'h20);
      check("R9 go via write", reg_rdata, 8'h3F);
      reg_wr = 1'b1; reg_wdata = 8'h00; conv_done_i = 1'b0;
      @(negedge clk); reg_wr = 1'b0;
      check("R9 abort", reg_rdata, 8'h1F);
      wr(8'h20);
      reg_wr = 1'b1; reg_wdata = 8'h20; conv_done_i = 1'b1;
      @(negedge clk); reg_wr = 1'b0; conv_done_i = 1'b0;
      check("R9 write beats done", reg_rdata, 8'h3F);

      wr(8'hE0);
      standby_i = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hE0;
      @(negedge clk); standby_i = 1'b0; reg_wr = 1'b0;
      check("R2 standby reload", reg_rdata, 8'h1F);
      check("R2 clk_sel", {7'd0, clk_sel_o}, 8'h00);

      src_sel_i = 1'b1; trig_n_i = 1'b1;
      ms = 3'b000; mprev = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         rdv = {ms, 5'h1F};
         check("R3 R4 R9 R10 R11 random word", reg_rdata, rdv);
         check("R4 R12 random start", {7'd0, start_o}, {7'd0, ms[0] & ~mprev});
         rw = ($urandom_range(0, 3) == 0);
         rt = ($urandom_range(0, 3) == 0);
         rd = ($urandom_range(0, 5) == 0);
         rs = ($urandom_range(0, 60) == 0);
         reg_wr = rw; reg_wdata = 8'($urandom);
         tmr_trig_i = rt; conv_done_i = rd; standby_i = rs;
         mprev = rs ? 1'b0 : ms[0];
         ms = model_next(ms, rw, reg_wdata, rt, rd, rs);
         @(negedge clk);
      end
      reg_wr = 1'b0; tmr_trig_i = 1'b0; conv_done_i = 1'b0; standby_i = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule